// File: doc/BRIEF.md
# Dual-Modulus Fractional-N Clock Divider

This block derives a slow output clock from a fast reference clock when the ratio between them is not an integer. A prescaler counts each output cycle as either 50 or 51 reference clocks. A modulus controller picks the length for every output cycle. Across a frame of 193 output cycles it picks the longer length exactly 70 times, so 9720 reference clocks make 193 output cycles and the average ratio is exact (for example 77.76 MHz to 1.544 MHz, with frames repeating at 8 kHz).

The controller spreads the long cycles as evenly as the integers allow. It uses an error accumulator that gains 70 per output cycle and sheds 193 whenever it picks a long cycle. As a result the edge timing never strays more than one reference period from the ideal grid. Each output cycle is high for 25 reference clocks and low for the rest (25 or 26). A one-clock strobe marks the start of every output cycle, and a second strobe marks the start of every frame.

Everything runs on the reference clock. The modulus controller advances only on a per-output-cycle enable, so no derived clock exists anywhere in the block.

Top module: `fdiv_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, `div_o`, `cyc_start_o`, `frame_start_o` and `long_cycle_o` are all 0.
- R2: Every output cycle lasts either 50 or 51 reference clocks. `cyc_start_o` is high for exactly the first clock of each cycle and is 0 otherwise.
- R3: `div_o` is 1 for the first 25 clocks of every output cycle and 0 for the remaining 25 or 26 clocks.
- R4: `long_cycle_o` holds one value for a whole output cycle. It is 1 for a 51-clock cycle and 0 for a 50-clock cycle.
- R5: Number the output cycles n = 0, 1, 2, … from reset, and let m = n mod 193. Cycle n is long exactly when floor((m+1)·70/193) > floor(m·70/193).
- R6: Every complete frame of 193 output cycles contains exactly 70 long cycles and spans exactly 9720 reference clocks.
- R7: `frame_start_o` is a one-clock pulse that coincides with `cyc_start_o` of cycle 0 of each frame. It is 0 at every other clock.
- R8: Between two consecutive long cycles there are either one or two short cycles, including across frame boundaries.
- R9: Reset applied mid-frame restarts the sequence at cycle 0 with the error accumulator cleared. The first cycle after release starts one clock after release and carries the frame strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| div_o | output | 1 | Divided clock level |
| cyc_start_o | output | 1 | One-clock strobe on the first clock of each output cycle |
| frame_start_o | output | 1 | One-clock strobe on the first clock of each 193-cycle frame |
| long_cycle_o | output | 1 | 1 while the current output cycle is 51 clocks long |

## Verification
The only input besides the clock is reset, so the properties assume just two things. Reset must be released synchronously to the reference clock. After release, the clock must keep running without gaps, because the cycle-length and high-time properties count clocks from the last cycle strobe. The stimulus releases and asserts reset only on the falling clock edge. It drives no other input, so every pattern the design sees comes from its own sequencing: the first frame, a second full frame, and a restart forced in the middle of a cycle.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

  // Modulus chosen for the current output cycle
  typedef enum logic {
    MOD_SHORT = 1'b0,
    MOD_LONG  = 1'b1
  } mod_sel_e;

  localparam int unsigned DEF_SHORT_DIV      = 50;
  localparam int unsigned DEF_HIGH_TIME      = 25;
  localparam int unsigned DEF_FRAME_CYC      = 193;
  localparam int unsigned DEF_LONG_PER_FRAME = 70;

endpackage

// File: rtl/fdiv_modctl.sv
`timescale 1ns/1ps
// Modulus controller: error accumulator plus frame position, both advanced
// once per output cycle through adv_i.
module fdiv_modctl
  import fdiv_pkg::*;
#(
  parameter int unsigned FRAME_CYC      = DEF_FRAME_CYC,
  parameter int unsigned LONG_PER_FRAME = DEF_LONG_PER_FRAME
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  output mod_sel_e sel_o,
  output logic     frame_head_o
);

  localparam int unsigned ACC_W = $clog2(FRAME_CYC + LONG_PER_FRAME);
  localparam int unsigned IDX_W = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             take_long;

  always_comb begin
    acc_sum   = acc_q + ACC_W'(LONG_PER_FRAME);
    take_long = (acc_sum >= ACC_W'(FRAME_CYC));
    acc_d     = acc_q;
    idx_d     = idx_q;
    if (adv_i) begin
      acc_d = take_long ? (acc_sum - ACC_W'(FRAME_CYC)) : acc_sum;
      idx_d = (idx_q == IDX_W'(FRAME_CYC - 1)) ? '0 : (idx_q + IDX_W'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  assign sel_o        = take_long ? MOD_LONG : MOD_SHORT;
  assign frame_head_o = (idx_q == '0);

endmodule

// File: rtl/fdiv_prescaler.sv
`timescale 1ns/1ps
// Dual-modulus counter: counts SHORT_DIV or SHORT_DIV+1 clocks per cycle.
module fdiv_prescaler
  import fdiv_pkg::*;
#(
  parameter  int unsigned SHORT_DIV = DEF_SHORT_DIV,
  localparam int unsigned CNT_W     = $clog2(SHORT_DIV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  mod_sel_e         sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;

  always_comb begin
    last_cnt = (sel_i == MOD_LONG) ? CNT_W'(SHORT_DIV) : CNT_W'(SHORT_DIV - 1);
    wrap_o   = en_i && (cnt_q == last_cnt);
    if (!en_i)       cnt_d = cnt_q;
    else if (wrap_o) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/fdiv_shaper.sv
`timescale 1ns/1ps
// Output decode: duty-cycle shaping and strobes from registered state.
module fdiv_shaper
  import fdiv_pkg::*;
#(
  parameter int unsigned HIGH_TIME = DEF_HIGH_TIME,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             frame_head_i,
  input  mod_sel_e         sel_i,
  output logic             div_o,
  output logic             cyc_start_o,
  output logic             frame_start_o,
  output logic             long_o
);

  logic cycle_head;

  always_comb begin
    cycle_head    = run_i && (cnt_i == '0);
    div_o         = run_i && (cnt_i < CNT_W'(HIGH_TIME));
    cyc_start_o   = cycle_head;
    frame_start_o = cycle_head && frame_head_i;
    long_o        = run_i && (sel_i == MOD_LONG);
  end

endmodule

// File: rtl/fdiv_top.sv
`timescale 1ns/1ps
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int unsigned SHORT_DIV      = DEF_SHORT_DIV,
  parameter int unsigned HIGH_TIME      = DEF_HIGH_TIME,
  parameter int unsigned FRAME_CYC      = DEF_FRAME_CYC,
  parameter int unsigned LONG_PER_FRAME = DEF_LONG_PER_FRAME
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o,
  output logic cyc_start_o,
  output logic frame_start_o,
  output logic long_cycle_o
);

  localparam int unsigned CNT_W = $clog2(SHORT_DIV + 1);

  logic             run_q, run_d;
  logic             wrap;
  logic             frame_head;
  logic [CNT_W-1:0] cnt;
  mod_sel_e         sel;

  // Counting starts on the first edge after reset release
  always_comb run_d = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  fdiv_modctl #(
    .FRAME_CYC     (FRAME_CYC),
    .LONG_PER_FRAME(LONG_PER_FRAME)
  ) u_modctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (wrap),
    .sel_o       (sel),
    .frame_head_o(frame_head)
  );

  fdiv_prescaler #(
    .SHORT_DIV(SHORT_DIV)
  ) u_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run_q),
    .sel_i (sel),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  fdiv_shaper #(
    .HIGH_TIME(HIGH_TIME),
    .CNT_W    (CNT_W)
  ) u_shaper (
    .run_i        (run_q),
    .cnt_i        (cnt),
    .frame_head_i (frame_head),
    .sel_i        (sel),
    .div_o        (div_o),
    .cyc_start_o  (cyc_start_o),
    .frame_start_o(frame_start_o),
    .long_o       (long_cycle_o)
  );

endmodule

// File: rtl/fdiv_chk.sv
`timescale 1ns/1ps
module fdiv_chk #(
  parameter int unsigned SHORT_DIV = 50,
  parameter int unsigned HIGH_TIME = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic div_o,
  input logic cyc_start_o,
  input logic frame_start_o,
  input logic long_cycle_o
);

  localparam int unsigned AGE_W = $clog2(SHORT_DIV + 3) + 1;

  logic [AGE_W-1:0] age_q;
  logic             started_q;

  // Clocks since the last cycle strobe, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q     <= '0;
      started_q <= 1'b0;
    end else begin
      if (cyc_start_o)    age_q <= AGE_W'(1);
      else if (age_q != '1) age_q <= age_q + AGE_W'(1);
      if (cyc_start_o)    started_q <= 1'b1;
    end
  end

  // R2
  cycle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && cyc_start_o) |->
      (age_q == AGE_W'(SHORT_DIV) || age_q == AGE_W'(SHORT_DIV + 1)));

  // R4
  long_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && cyc_start_o) |-> ((age_q == AGE_W'(SHORT_DIV + 1)) == $past(long_cycle_o)));

  // R4
  long_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !cyc_start_o) |-> $stable(long_cycle_o));

  // R3
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> div_o);

  // R3
  high_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !cyc_start_o) |-> (div_o == (age_q < AGE_W'(HIGH_TIME))));

  // R7
  frame_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> cyc_start_o);

endmodule

bind fdiv_top fdiv_chk #(
  .SHORT_DIV(SHORT_DIV),
  .HIGH_TIME(HIGH_TIME)
) u_fdiv_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .div_o        (div_o),
  .cyc_start_o  (cyc_start_o),
  .frame_start_o(frame_start_o),
  .long_cycle_o (long_cycle_o)
);

// File: tb/tb_fdiv_top.sv
`timescale 1ns/1ps
module tb_fdiv_top;

  localparam int SHORT = 50;
  localparam int HIGHT = 25;
  localparam int FRAME = 193;
  localparam int LONGS = 70;

  typedef struct {
    int len;
    bit lng;
    bit fs;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_o, cyc_start, frame_start, long_cyc;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  fdiv_top dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .div_o        (div_o),
    .cyc_start_o  (cyc_start),
    .frame_start_o(frame_start),
    .long_cycle_o (long_cyc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // Driver: expected items per output cycle, from R5 / R7
  task automatic push_cycles(input int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      exp_t e;
      int m;
      m = n % FRAME;
      e.lng = (((m + 1) * LONGS) / FRAME) > ((m * LONGS) / FRAME);
      e.len = SHORT + (e.lng ? 1 : 0);
      e.fs  = (m == 0);
      exp_q.push_back(e);
    end
  endtask

  // Monitor state
  bit in_cyc = 0;
  int len = 0, hi = 0;
  bit fell = 0, c_long = 0, c_fs = 0;
  int fr_cyc = 0, fr_long = 0, fr_clks = 0;
  bit seen_long = 0;
  int gap = 0;

  task automatic finish_cycle();
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(len == e.len, "R2/R5 cycle length", len, e.len);
      chk(c_long == e.lng, "R4/R5 long flag", int'(c_long), int'(e.lng));
      chk(c_fs == e.fs, "R7 frame strobe", int'(c_fs), int'(e.fs));
    end
    chk(hi == HIGHT, "R3 high time", hi, HIGHT);
    chk((c_long ? SHORT + 1 : SHORT) == len, "R4 flag vs length", len, c_long ? SHORT + 1 : SHORT);
    if (c_fs) begin
      if (fr_cyc == FRAME) begin
        chk(fr_long == LONGS, "R6 long count", fr_long, LONGS);
        chk(fr_clks == FRAME * SHORT + LONGS, "R6 frame clocks", fr_clks, FRAME * SHORT + LONGS);
      end
      fr_cyc = 0; fr_long = 0; fr_clks = 0;
    end
    fr_cyc++;
    fr_long += c_long ? 1 : 0;
    fr_clks += len;
    if (c_long) begin
      if (seen_long) chk(gap == 1 || gap == 2, "R8 short gap", gap, 2);
      seen_long = 1;
      gap = 0;
    end else begin
      gap++;
    end
    done_cnt++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      in_cyc = 0; fr_cyc = 0; fr_long = 0; fr_clks = 0; seen_long = 0; gap = 0;
    end else if (cyc_start) begin
      if (in_cyc) finish_cycle();
      in_cyc = 1; len = 1; fell = 0;
      hi = div_o ? 1 : 0;
      c_long = long_cyc;
      c_fs = frame_start;
    end else if (in_cyc) begin
      len++;
      if (frame_start) chk(0, "R7 strobe outside cycle start", 1, 0);
      if (long_cyc != c_long) chk(0, "R4 flag changed mid-cycle", int'(long_cyc), int'(c_long));
      if (div_o) begin
        if (fell) chk(0, "R3 second high phase", 1, 0);
        hi++;
      end else begin
        fell = 1;
      end
    end
  end

  task automatic check_reset_outputs(input string tag);
    chk(div_o == 0, {tag, " div_o"}, int'(div_o), 0);
    chk(cyc_start == 0, {tag, " cyc_start"}, int'(cyc_start), 0);
    chk(frame_start == 0, {tag, " frame_start"}, int'(frame_start), 0);
    chk(long_cyc == 0, {tag, " long_cycle"}, int'(long_cyc), 0);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check_reset_outputs("R1 in reset");
    push_cycles(400);
    rst_n = 1'b1;
    check_reset_outputs("R1 before first edge");
    @(negedge clk);
    // R7: first frame strobe one clock after release
    chk(frame_start == 1, "R7 first frame strobe", int'(frame_start), 1);
    chk(div_o == 1, "R3 first cycle high", int'(div_o), 1);
    while (done_cnt < 400) @(negedge clk);

    // R9: reset in the middle of a cycle, sequence restarts from cycle 0
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_outputs("R1/R9 mid-run reset");
    repeat (4) @(negedge clk);
    check_reset_outputs("R9 held reset");
    exp_q.delete();
    done_cnt = 0;
    push_cycles(250);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_start == 1 && cyc_start == 1, "R9 restart at frame head", int'(frame_start), 1);
    while (done_cnt < 250) @(negedge clk);

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule